// File: doc/BRIEF.md
# Asynchronous Processor Bus Slave

This block lets an external processor reach a small register bank inside logic that runs on a local 200 MHz clock. The processor's own clock is not visible. Its bus timing therefore has no known phase relationship to the local clock, and the whole interface is handled as asynchronous. The processor drives an active-low select, an active-low cycle strobe, a read-not-write mode line and an address. Data travels over a bus that is split here into an input, an output and an output enable, which together form the pad tristate.

Only the two cycle-control lines go through a multi-flop synchronizer. The synchronized cycle-active level is then delayed by further local clocks, so that sampling stays clear of the skew window. Its rising edge loads the address, write data and mode into one register rank, once per transaction. The transaction is then decoded into one register write, or into one register read that is driven onto the data bus until the cycle ends. The processor must hold address, data and mode stable across the cycle for longer than the synchronizer and delay latency.

Top module: `pbus_async_slave`

## Requirements
- R1: A cycle is active while `bus_sel_n` and `bus_strb_n` are both low (active low). The block acts on a cycle only after `SYNC_STAGES` (default 2) synchronizer clocks plus `DELAY` (default 1) further clocks. The bus must be stable for at least 8 local clocks from the start of the cycle.
- R2: A synchronous active-high `rst` leaves `bus_data_oe` low with `bus_data_o` zero and the capture logic idle. After reset, all 16 registers read back as zero.
- R3: A cycle with `bus_rnw` = 0 stores `bus_data_i` into the register selected by `bus_addr`. There are 2^`ADDR_W` registers, default 16 of 16 bits.
- R4: Each transaction gives exactly one write or read event, even when the strobe is held for many clocks. Changes on address, data or mode after capture have no effect.
- R5: A cycle with `bus_rnw` = 1 raises `bus_data_oe` and drives the addressed register on `bus_data_o` within 8 local clocks of the cycle becoming active.
- R6: `bus_data_oe` stays low for the whole of a write cycle.
- R7: `bus_data_oe` falls within 4 local clocks after select or strobe returns high, and `bus_data_o` is then zero.
- R8: While `bus_sel_n` is high, strobe activity causes no register write and no drive of the data bus.
- R9: Transactions separated by 3 or more idle local clocks are each recognised as their own transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local 200 MHz clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel_n | input | 1 | Processor chip select, active low, asynchronous |
| bus_strb_n | input | 1 | Processor cycle strobe, active low, asynchronous |
| bus_rnw | input | 1 | Cycle mode: 1 read, 0 write |
| bus_addr | input | ADDR_W | Register address |
| bus_data_i | input | DATA_W | Data bus as seen from the pad |
| bus_data_o | output | DATA_W | Read data toward the pad |
| bus_data_oe | output | 1 | Pad output enable for the data bus |

## Verification
The hardest case to reach from the ports is a strobe held far beyond the capture point while the processor has already moved address and data on. Only a second event, or a late capture, would show up there. The bench holds such a write cycle for over twenty clocks with a different address and value placed on the bus after capture, then reads both locations back. It also runs transactions separated by the minimum idle gap, so that a missed delayed edge appears as a lost write. It also sweeps all addresses for reset contents, writes and read-back.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
   // cycle mode carried by the capture rank
   typedef enum logic {
      MODE_WRITE = 1'b0,
      MODE_READ  = 1'b1
   } pbus_mode_e;

   // reset level of the active-low cycle controls
   localparam logic CTRL_IDLE = 1'b1;
endpackage

// File: rtl/pbus_sync.sv
module pbus_sync #(
   parameter int WIDTH   = 2,
   parameter int STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pbus_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk) begin
      if (rst) stg[0] <= {WIDTH{RST_VAL}};
      else     stg[0] <= d_async;
   end

   generate
      for (genvar i = 1; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk) begin
            if (rst) stg[i] <= {WIDTH{RST_VAL}};
            else     stg[i] <= stg[i-1];
         end
      end
   endgenerate

   assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/pbus_cycle_detect.sv
module pbus_cycle_detect #(
   parameter int DELAY = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic act_s,
   output logic start_p
);
   generate
      if (DELAY < 1) begin : g_bad_delay
         $error("pbus_cycle_detect: DELAY must be at least 1");
      end
   endgenerate

   logic dly_out;
   logic dly_prev;

   generate
      if (DELAY == 1) begin : g_single
         logic dq;
         always_ff @(posedge clk) begin
            if (rst) dq <= 1'b0;
            else     dq <= act_s;
         end
         assign dly_out = dq;
      end else begin : g_chain
         logic [DELAY-1:0] dsr;
         always_ff @(posedge clk) begin
            if (rst) dsr <= '0;
            else     dsr <= {dsr[DELAY-2:0], act_s};
         end
         assign dly_out = dsr[DELAY-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) dly_prev <= 1'b0;
      else     dly_prev <= dly_out;
   end

   assign start_p = dly_out & ~dly_prev;
endmodule

// File: rtl/pbus_regbank.sv
module pbus_regbank #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_entry
         always_ff @(posedge clk) begin
            if (rst)
               mem[e] <= '0;
            else if (wr_en && (wr_addr == ADDR_W'(e)))
               mem[e] <= wr_data;
         end
      end
   endgenerate

   assign rd_data = mem[rd_addr];
endmodule

// File: rtl/pbus_async_slave.sv
module pbus_async_slave #(
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2,
   parameter int DELAY       = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bus_sel_n,
   input  logic              bus_strb_n,
   input  logic              bus_rnw,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_data_i,
   output logic [DATA_W-1:0] bus_data_o,
   output logic              bus_data_oe
);
   import pbus_pkg::*;

   generate
      if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_aw
         $error("pbus_async_slave: ADDR_W out of range 1..8");
      end
      if (DATA_W < 1) begin : g_bad_dw
         $error("pbus_async_slave: DATA_W must be positive");
      end
   endgenerate

   // control synchronizer (only the cycle-control lines)
   logic [1:0] ctl_s;
   pbus_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(CTRL_IDLE)) u_sync (
      .clk     (clk),
      .rst     (rst),
      .d_async ({bus_sel_n, bus_strb_n}),
      .q_sync  (ctl_s)
   );

   logic act_s;
   assign act_s = ~ctl_s[1] & ~ctl_s[0];

   // delayed rising edge of the synchronized cycle
   logic start_p;
   pbus_cycle_detect #(.DELAY(DELAY)) u_det (
      .clk     (clk),
      .rst     (rst),
      .act_s   (act_s),
      .start_p (start_p)
   );

   // single capture rank
   logic [ADDR_W-1:0] cap_addr;
   logic [DATA_W-1:0] cap_data;
   pbus_mode_e        cap_mode;
   logic              cap_vld;
   logic              cap_rnw;

   always_ff @(posedge clk) begin
      if (rst) begin
         cap_addr <= '0;
         cap_data <= '0;
         cap_mode <= MODE_WRITE;
         cap_vld  <= 1'b0;
      end else begin
         cap_vld <= start_p;
         if (start_p) begin
            cap_addr <= bus_addr;
            cap_data <= bus_data_i;
            cap_mode <= pbus_mode_e'(bus_rnw);
         end
      end
   end

   assign cap_rnw = (cap_mode == MODE_READ);

   logic wr_en;
   assign wr_en = cap_vld & ~cap_rnw;

   logic [DATA_W-1:0] rd_data;
   pbus_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_addr (cap_addr),
      .wr_data (cap_data),
      .rd_addr (cap_addr),
      .rd_data (rd_data)
   );

   // read drive, released once the synchronized cycle is gone
   logic [DATA_W-1:0] rd_q;
   logic              data_oe;

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_q    <= '0;
         data_oe <= 1'b0;
      end else if (!act_s) begin
         data_oe <= 1'b0;
      end else if (cap_vld && cap_rnw) begin
         rd_q    <= rd_data;
         data_oe <= 1'b1;
      end
   end

   assign bus_data_oe = data_oe;
   assign bus_data_o  = rd_q & {DATA_W{data_oe}};
endmodule

// File: rtl/pbus_async_slave_chk.sv
module pbus_async_slave_chk (
   input logic clk,
   input logic rst,
   input logic act_s,
   input logic cap_vld,
   input logic cap_rnw,
   input logic wr_en,
   input logic data_oe
);
   // R2: after a reset clock, output enable and capture are idle
   a_r2_reset_idle: assert property (@(posedge clk)
      $past(rst) |-> (!data_oe && !cap_vld));

   // R4: the capture event is a single-cycle pulse per transaction
   a_r4_single_event: assert property (@(posedge clk) disable iff (rst)
      cap_vld |=> !cap_vld);

   // R4: at most one write per transaction
   a_r4_single_write: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> !wr_en);

   // R6: the bus is only driven for a read capture
   a_r6_oe_read_only: assert property (@(posedge clk) disable iff (rst)
      data_oe |-> cap_rnw);

   // R7: drive is released once the synchronized cycle has ended
   a_r7_release: assert property (@(posedge clk) disable iff (rst)
      !$past(act_s) |-> !data_oe);

   // R1: a capture never happens without a synchronized active cycle
   a_r1_capture_needs_cycle: assert property (@(posedge clk) disable iff (rst)
      cap_vld |-> $past(act_s));
endmodule

bind pbus_async_slave pbus_async_slave_chk chk_i (
   .clk     (clk),
   .rst     (rst),
   .act_s   (act_s),
   .cap_vld (cap_vld),
   .cap_rnw (cap_rnw),
   .wr_en   (wr_en),
   .data_oe (data_oe)
);

// File: tb/pbus_async_slave_tb_top.sv
module pbus_async_slave_tb_top;
   localparam int AW = 4;
   localparam int DW = 16;
   localparam int N  = 1 << AW;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          sel_n = 1'b1;
   logic          strb_n = 1'b1;
   logic          rnw = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout;
   logic          oe;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   pbus_async_slave #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
      .clk         (clk),
      .rst         (rst),
      .bus_sel_n   (sel_n),
      .bus_strb_n  (strb_n),
      .bus_rnw     (rnw),
      .bus_addr    (addr),
      .bus_data_i  (din),
      .bus_data_o  (dout),
      .bus_data_oe (oe)
   );

   function automatic logic [DW-1:0] pat(input int a, input int k);
      return DW'((a * 16'h1111) ^ (16'hA5C3 + k * 16'h0F1E));
   endfunction

   task automatic check(input bit ok, input string tag,
                        input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one bus cycle; returns read value and oe seen at the end of the hold
   task automatic cycle(input bit rd, input int a, input logic [DW-1:0] d,
                        input bit use_sel, input int hold, input int idle,
                        output logic [DW-1:0] rv, output logic oe_seen);
      @(negedge clk);
      rnw    = rd;
      addr   = AW'(a);
      din    = d;
      sel_n  = ~use_sel;
      strb_n = 1'b0;
      repeat (hold) @(negedge clk);
      rv      = dout;
      oe_seen = oe;
      strb_n  = 1'b1;
      sel_n   = 1'b1;
      repeat (idle) @(negedge clk);
   endtask

   logic [DW-1:0] model [N];

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] rv;
      logic          oes;
      repeat (4) @(negedge clk);
      // R2: reset state at the ports
      check(oe == 1'b0, "R2 oe in reset", DW'(oe), '0);
      check(dout == '0, "R2 data_o in reset", dout, '0);
      @(negedge clk);
      rst = 1'b0;
      for (int a = 0; a < N; a++) model[a] = '0;

      // R2: every register reads zero after reset
      for (int a = 0; a < N; a++) begin
         cycle(1'b1, a, '0, 1'b1, 8, 4, rv, oes);
         check(oes == 1'b1, "R2 read oe", DW'(oes), 1);
         check(rv == '0, "R2 reset contents", rv, '0);
      end

      // R3/R6: write sweep, oe must stay low in writes
      for (int k = 0; k < 2; k++) begin
         for (int a = 0; a < N; a++) begin
            cycle(1'b0, a, pat(a, k), 1'b1, 8, 4, rv, oes);
            model[a] = pat(a, k);
            check(oes == 1'b0, "R6 oe during write", DW'(oes), 0);
         end
         // R5/R7: read sweep, then release
         for (int a = 0; a < N; a++) begin
            cycle(1'b1, a, '0, 1'b1, 8, 4, rv, oes);
            check(oes == 1'b1, "R5 read oe", DW'(oes), 1);
            check(rv == model[a], "R3 R5 read back", rv, model[a]);
            check(oe == 1'b0, "R7 oe released", DW'(oe), 0);
            check(dout == '0, "R7 data_o after release", dout, '0);
         end
      end

      // R4: long write, bus changes after capture
      @(negedge clk);
      rnw = 1'b0; addr = AW'(3); din = 16'h1234; sel_n = 1'b0; strb_n = 1'b0;
      repeat (8) @(negedge clk);
      addr = AW'(4); din = 16'hBEEF; rnw = 1'b1;
      repeat (20) @(negedge clk);
      check(oe == 1'b0, "R4 no read from late mode change", DW'(oe), 0);
      strb_n = 1'b1; sel_n = 1'b1;
      repeat (4) @(negedge clk);
      model[3] = 16'h1234;
      cycle(1'b1, 3, '0, 1'b1, 8, 4, rv, oes);
      check(rv == 16'h1234, "R4 captured once at addr 3", rv, 16'h1234);
      cycle(1'b1, 4, '0, 1'b1, 8, 4, rv, oes);
      check(rv == model[4], "R4 addr 4 untouched", rv, model[4]);

      // R4: long read holds one value and drive
      cycle(1'b1, 5, '0, 1'b1, 30, 4, rv, oes);
      check(oes == 1'b1 && rv == model[5], "R4 long read", rv, model[5]);
      check(oe == 1'b0, "R7 release after long read", DW'(oe), 0);

      // R8: select high, strobe ignored
      cycle(1'b0, 6, 16'hDEAD, 1'b0, 10, 4, rv, oes);
      check(oes == 1'b0, "R8 no drive on deselected write", DW'(oes), 0);
      cycle(1'b1, 6, '0, 1'b0, 10, 4, rv, oes);
      check(oes == 1'b0, "R8 no drive on deselected read", DW'(oes), 0);
      cycle(1'b1, 6, '0, 1'b1, 8, 4, rv, oes);
      check(rv == model[6], "R8 register unchanged", rv, model[6]);

      // R9/R1: back-to-back writes with 3 idle clocks
      for (int a = 0; a < N; a++) begin
         cycle(1'b0, a, pat(a, 7), 1'b1, 8, 3, rv, oes);
         model[a] = pat(a, 7);
      end
      for (int a = 0; a < N; a++) begin
         cycle(1'b1, a, '0, 1'b1, 8, 3, rv, oes);
         check(oes == 1'b1 && rv == model[a], "R9 R1 back-to-back", rv, model[a]);
      end

      // R2: reset mid-read clears drive and contents
      @(negedge clk);
      rnw = 1'b1; addr = AW'(2); sel_n = 1'b0; strb_n = 1'b0;
      repeat (8) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check(oe == 1'b0, "R2 reset drops oe", DW'(oe), 0);
      strb_n = 1'b1; sel_n = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      repeat (4) @(negedge clk);
      cycle(1'b1, 2, '0, 1'b1, 8, 4, rv, oes);
      check(rv == '0, "R2 contents cleared", rv, '0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule